// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Adapter

This block sits between a host request/response bus and a single-port memory that only writes whole words. Reads and writes that cover every byte of the word are forwarded to the memory unchanged, in the same cycle. A write whose byte mask leaves some bytes out is turned into a short sequence instead. The block first reads the target word and keeps the returned data to itself. It then merges the new bytes into that word and writes the whole word back. Only the response to the write-back reaches the host.

While the sequence runs, the host request channel is held off. A counter of requests that the memory has accepted but not yet answered limits how many can be in flight. It is also how the block recognises its own read response. Any answers to earlier requests still reach the host, in order, before the internal read returns. An error input forces a request straight through and suppresses the sequence.

Top module: `rmw_adapter`

## Requirements
- R1: When no sequence is running, a read (opcode 4), or a write (opcode 0 full, opcode 1 partial) whose mask is all ones, is offered to the memory with the host's opcode, address, mask and data unchanged. The host and the memory accept it in the same cycle.
- R2: When no sequence is running and err_in_i is low, a write (opcode 0 or 1) whose mask is not all ones is sent to the memory as a read (opcode 4) of the same address in the cycle the host hands it over.
- R3: After the internal read data returns, the next memory request is a full-data write (opcode 0) to the held address with an all-ones mask. Its data takes byte i (bits 8i+7..8i) from the host write where mask bit i is 1, and from the read data where it is 0.
- R4: The internal read response is consumed by the block and never shown to the host. The host receives exactly one response per accepted request, in request order.
- R5: From the cycle after a partial write is accepted until the cycle in which the memory accepts the write-back, hreq_ready_o stays low.
- R6: hreq_ready_o is high only when mreq_ready_i is high, no sequence is running, and fewer than MAX_OUT memory requests are awaiting a response. With MAX_OUT requests outstanding, no new request is offered to the memory.
- R7: With err_in_i high and no sequence running, a partial write is forwarded unchanged, keeping its opcode and mask, and no sequence starts.
- R8: Response data and the error flag pass from the memory to the host unchanged for every response that is not the internal read.
- R9: An asynchronous active-low reset leaves the block idle: no memory request, no host response, the outstanding count at zero and hreq_ready_o following mreq_ready_i.
- R10: Responses to requests issued before a partial write reach the host while the block waits for its own read, and the internal read is recognised only when it is the sole outstanding request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hreq_valid_i | input | 1 | Host request valid |
| hreq_ready_o | output | 1 | Host request ready |
| hreq_op_i | input | 3 | Host opcode: 0 full write, 1 partial write, 4 read |
| hreq_addr_i | input | AW | Host word address |
| hreq_mask_i | input | DW/8 | Host byte mask |
| hreq_data_i | input | DW | Host write data |
| err_in_i | input | 1 | Error indication; forces pass-through |
| hrsp_valid_o | output | 1 | Host response valid |
| hrsp_ready_i | input | 1 | Host response ready |
| hrsp_data_o | output | DW | Host response data |
| hrsp_err_o | output | 1 | Host response error flag |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory request ready |
| mreq_op_o | output | 3 | Memory opcode |
| mreq_addr_o | output | AW | Memory word address |
| mreq_mask_o | output | DW/8 | Memory byte mask |
| mreq_data_o | output | DW | Memory write data |
| mrsp_valid_i | input | 1 | Memory response valid |
| mrsp_ready_o | output | 1 | Memory response ready |
| mrsp_data_i | input | DW | Memory response data |
| mrsp_err_i | input | 1 | Memory response error flag |

## Verification
The assertions assume the memory answers every accepted request exactly once and in order. They also assume the host holds a request steady while it is waiting, since the forwarding checks compare memory outputs with the host inputs in the same cycle. The bench memory model queues one response per accepted request, so each answer appears no earlier than the cycle after acceptance. The bench drives the request fields only between handshakes and toggles both ready inputs at random to exercise back-pressure without breaking these assumptions.

// File: rtl/rmw_adapter.sv
`timescale 1ns/1ps
module rmw_adapter #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int MAX_OUT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hreq_valid_i,
  output logic              hreq_ready_o,
  input  logic [2:0]        hreq_op_i,
  input  logic [AW-1:0]     hreq_addr_i,
  input  logic [DW/8-1:0]   hreq_mask_i,
  input  logic [DW-1:0]     hreq_data_i,
  input  logic              err_in_i,
  output logic              hrsp_valid_o,
  input  logic              hrsp_ready_i,
  output logic [DW-1:0]     hrsp_data_o,
  output logic              hrsp_err_o,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic [2:0]        mreq_op_o,
  output logic [AW-1:0]     mreq_addr_o,
  output logic [DW/8-1:0]   mreq_mask_o,
  output logic [DW-1:0]     mreq_data_o,
  input  logic              mrsp_valid_i,
  output logic              mrsp_ready_o,
  input  logic [DW-1:0]     mrsp_data_i,
  input  logic              mrsp_err_i
);
  localparam int NB = DW / 8;
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;
  localparam logic [1:0] ST_PASS = 2'd0;
  localparam logic [1:0] ST_WAIT = 2'd1;
  localparam logic [1:0] ST_WB   = 2'd2;

  logic [1:0]    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [NB-1:0] mask_q;
  logic [DW-1:0] wdata_q, rdata_q, merged;

  logic is_wr, partial, stall, room, rmw_start;
  logic host_ack, mem_a_ack, mem_d_ack, rd_wait, in_wb;

  assign is_wr     = (hreq_op_i == OP_PUT_FULL) | (hreq_op_i == OP_PUT_PART);
  assign partial   = hreq_valid_i & is_wr & ~(&hreq_mask_i);
  assign stall     = state_q != ST_PASS;
  assign in_wb     = state_q == ST_WB;
  assign room      = cnt_q < CW'(MAX_OUT);
  assign rmw_start = partial & ~err_in_i & ~stall;
  assign rd_wait   = (state_q == ST_WAIT) & (cnt_q == CW'(1));

  assign host_ack  = hreq_valid_i & hreq_ready_o;
  assign mem_a_ack = mreq_valid_o & mreq_ready_i;
  assign mem_d_ack = mrsp_valid_i & mrsp_ready_o;

  for (genvar i = 0; i < NB; i++) begin : g_merge
    assign merged[i*8 +: 8] = mask_q[i] ? wdata_q[i*8 +: 8] : rdata_q[i*8 +: 8];
  end

  assign hreq_ready_o = mreq_ready_i & ~stall & room;
  assign mreq_valid_o = in_wb | (hreq_valid_i & ~stall & room);
  assign mreq_op_o    = in_wb ? OP_PUT_FULL : (rmw_start ? OP_GET : hreq_op_i);
  assign mreq_addr_o  = in_wb ? addr_q : hreq_addr_i;
  assign mreq_mask_o  = in_wb ? {NB{1'b1}} : hreq_mask_i;
  assign mreq_data_o  = in_wb ? merged : hreq_data_i;

  assign mrsp_ready_o = hrsp_ready_i | rd_wait;
  assign hrsp_valid_o = mrsp_valid_i & ~rd_wait;
  assign hrsp_data_o  = mrsp_data_i;
  assign hrsp_err_o   = mrsp_err_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PASS: if (rmw_start && host_ack) state_d = ST_WAIT;
      ST_WAIT: if (mem_d_ack && rd_wait)  state_d = ST_WB;
      ST_WB:   if (mem_a_ack)             state_d = ST_PASS;
      default: state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PASS;
      cnt_q   <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (mem_a_ack && !mem_d_ack)      cnt_q <= cnt_q + CW'(1);
      else if (!mem_a_ack && mem_d_ack) cnt_q <= cnt_q - CW'(1);
      if (rmw_start && host_ack) begin
        addr_q  <= hreq_addr_i;
        mask_q  <= hreq_mask_i;
        wdata_q <= hreq_data_i;
      end
      if (mem_d_ack && rd_wait) rdata_q <= mrsp_data_i;
    end
  end
endmodule

// File: rtl/rmw_adapter_chk.sv
`timescale 1ns/1ps
module rmw_adapter_chk #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int MAX_OUT = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           hreq_valid_i,
  input logic                           hreq_ready_o,
  input logic [2:0]                     hreq_op_i,
  input logic [AW-1:0]                  hreq_addr_i,
  input logic [DW/8-1:0]                hreq_mask_i,
  input logic [DW-1:0]                  hreq_data_i,
  input logic                           err_in_i,
  input logic                           hrsp_valid_o,
  input logic                           hrsp_ready_i,
  input logic                           mreq_valid_o,
  input logic [2:0]                     mreq_op_o,
  input logic [AW-1:0]                  mreq_addr_o,
  input logic [DW/8-1:0]                mreq_mask_o,
  input logic [DW-1:0]                  mreq_data_o,
  input logic                           mrsp_valid_i,
  input logic                           mrsp_ready_o,
  input logic [1:0]                     state_q,
  input logic [$clog2(MAX_OUT+1)-1:0]   cnt_q
);
  localparam int CW = $clog2(MAX_OUT + 1);
  logic wr_op, full_mask, pw_take;
  assign wr_op     = (hreq_op_i == 3'd0) || (hreq_op_i == 3'd1);
  assign full_mask = &hreq_mask_i;
  assign pw_take   = (state_q == 2'd0) && hreq_valid_i && hreq_ready_o && wr_op && !full_mask && !err_in_i;

  a_r1_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == 2'd0) && hreq_valid_i && (!wr_op || full_mask)) |->
      (mreq_op_o == hreq_op_i && mreq_addr_o == hreq_addr_i &&
       mreq_mask_o == hreq_mask_i && mreq_data_o == hreq_data_i));

  a_r2_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_take |-> (mreq_op_o == 3'd4 && mreq_addr_o == hreq_addr_i));

  a_r2_enter_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_take |=> (state_q == 2'd1));

  a_r3_wait_to_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == 2'd1) && mrsp_valid_i && mrsp_ready_o && cnt_q == CW'(1)) |=> (state_q == 2'd2));

  a_r3_wb_format: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 2'd2) |-> (mreq_valid_o && mreq_op_o == 3'd0 && (&mreq_mask_o)));

  a_r4_rsp_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hrsp_valid_o && hrsp_ready_i) |-> (mrsp_valid_i && mrsp_ready_o));

  a_r4_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == 2'd1) && cnt_q == CW'(1)) |-> !hrsp_valid_o);

  a_r5_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != 2'd0) |-> !hreq_ready_o);

  a_r6_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(MAX_OUT) && state_q == 2'd0) |-> (!hreq_ready_o && !mreq_valid_o));

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_OUT));

  a_r7_err_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == 2'd0) && hreq_valid_i && err_in_i) |->
      (mreq_op_o == hreq_op_i && mreq_mask_o == hreq_mask_i));

  a_r7_err_no_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == 2'd0) && hreq_valid_i && hreq_ready_o && err_in_i) |=> (state_q == 2'd0));
endmodule

bind rmw_adapter rmw_adapter_chk #(.AW(AW), .DW(DW), .MAX_OUT(MAX_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .hreq_valid_i(hreq_valid_i), .hreq_ready_o(hreq_ready_o), .hreq_op_i(hreq_op_i),
  .hreq_addr_i(hreq_addr_i), .hreq_mask_i(hreq_mask_i), .hreq_data_i(hreq_data_i),
  .err_in_i(err_in_i), .hrsp_valid_o(hrsp_valid_o), .hrsp_ready_i(hrsp_ready_i),
  .mreq_valid_o(mreq_valid_o), .mreq_op_o(mreq_op_o), .mreq_addr_o(mreq_addr_o),
  .mreq_mask_o(mreq_mask_o), .mreq_data_o(mreq_data_o),
  .mrsp_valid_i(mrsp_valid_i), .mrsp_ready_o(mrsp_ready_o),
  .state_q(state_q), .cnt_q(cnt_q)
);

// File: tb/rmw_adapter_tb.sv
`timescale 1ns/1ps
module rmw_adapter_tb;
  localparam int AW = 8, DW = 32, NB = 4, MAXO = 2;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic hreq_valid_i = 0, hreq_ready_o, err_in_i = 0;
  logic [2:0] hreq_op_i = 0;
  logic [AW-1:0] hreq_addr_i = 0;
  logic [NB-1:0] hreq_mask_i = 0;
  logic [DW-1:0] hreq_data_i = 0;
  logic hrsp_valid_o, hrsp_ready_i = 1, hrsp_err_o;
  logic [DW-1:0] hrsp_data_o;
  logic mreq_valid_o, mreq_ready_i = 1;
  logic [2:0] mreq_op_o;
  logic [AW-1:0] mreq_addr_o;
  logic [NB-1:0] mreq_mask_o;
  logic [DW-1:0] mreq_data_o;
  logic mrsp_valid_i = 0, mrsp_ready_o, mrsp_err_i = 0;
  logic [DW-1:0] mrsp_data_i = 0;

  rmw_adapter #(.AW(AW), .DW(DW), .MAX_OUT(MAXO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .hreq_valid_i, .hreq_ready_o, .hreq_op_i, .hreq_addr_i, .hreq_mask_i, .hreq_data_i,
    .err_in_i, .hrsp_valid_o, .hrsp_ready_i, .hrsp_data_o, .hrsp_err_o,
    .mreq_valid_o, .mreq_ready_i, .mreq_op_o, .mreq_addr_o, .mreq_mask_o, .mreq_data_o,
    .mrsp_valid_i, .mrsp_ready_o, .mrsp_data_i, .mrsp_err_i
  );

  int nchk = 0, nfail = 0, seq_viol = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] gold [16];
  logic [DW:0] mq [$];
  logic [DW:0] expq [$];
  bit rmode = 0, hold_rsp = 0, acc = 0, in_seq = 0;
  logic [AW-1:0] seq_addr;
  logic [NB-1:0] seq_mask;
  logic [DW-1:0] seq_data;
  logic [2:0] cap_op;
  logic [NB-1:0] cap_mask;
  logic [DW-1:0] cap_data;

  function automatic logic [DW-1:0] merge(logic [NB-1:0] m, logic [DW-1:0] nw, logic [DW-1:0] old);
    logic [DW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = m[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [DW:0] act, logic [DW:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    logic [3:0] a;
    bit part;
    @(negedge clk);
    acc = 0;
    if (hrsp_valid_o && hrsp_ready_i) begin
      if (expq.size() == 0) chk(0, "R4 extra host response", {hrsp_err_o, hrsp_data_o}, '0);
      else begin
        chk({hrsp_err_o, hrsp_data_o} == expq[0], "R8 response data", {hrsp_err_o, hrsp_data_o}, expq[0]);
        void'(expq.pop_front());
      end
    end
    if (in_seq && hreq_ready_o) seq_viol++;
    if (mrsp_valid_i && mrsp_ready_o) void'(mq.pop_front());
    if (mreq_valid_o && mreq_ready_i) begin
      a = mreq_addr_o[3:0];
      if (in_seq) begin
        chk(mreq_op_o == 3'd0 && mreq_mask_o == 4'hF && mreq_addr_o == seq_addr &&
            mreq_data_o == merge(seq_mask, seq_data, mem[a]), "R3 write-back",
            {mreq_op_o[0], mreq_data_o}, {1'b0, merge(seq_mask, seq_data, mem[a])});
        in_seq = 0;
      end
      if (mreq_op_o == 3'd4) mq.push_back({a == 4'd15, mem[a]});
      else begin
        mem[a] = merge(mreq_mask_o, mreq_data_o, mem[a]);
        mq.push_back('0);
      end
    end
    if (hreq_valid_i && hreq_ready_o) begin
      acc = 1;
      a = hreq_addr_i[3:0];
      part = (hreq_op_i != 3'd4) && (hreq_mask_i != 4'hF);
      if (part && !err_in_i) begin
        chk(mreq_op_o == 3'd4 && mreq_addr_o == hreq_addr_i, "R2 read issue",
            {1'b0, 29'd0, mreq_op_o}, 33'd4);
        in_seq = 1; seq_addr = hreq_addr_i; seq_mask = hreq_mask_i; seq_data = hreq_data_i;
      end else begin
        chk(mreq_op_o == hreq_op_i && mreq_addr_o == hreq_addr_i && mreq_mask_o == hreq_mask_i &&
            mreq_data_o == hreq_data_i, part ? "R7 error forward" : "R1 forward",
            {1'b0, mreq_data_o}, {1'b0, hreq_data_i});
      end
      if (hreq_op_i == 3'd4) expq.push_back({a == 4'd15, gold[a]});
      else begin
        gold[a] = merge(hreq_mask_i, hreq_data_i, gold[a]);
        expq.push_back('0);
      end
    end
    @(posedge clk);
    #1;
    if (acc) begin hreq_valid_i = 0; err_in_i = 0; end
    mrsp_valid_i = mq.size() != 0;
    {mrsp_err_i, mrsp_data_i} = (mq.size() != 0) ? mq[0] : '0;
    if (rmode) begin
      mreq_ready_i = ($urandom % 4) != 0;
      hrsp_ready_i = ($urandom % 4) != 0;
    end else begin
      mreq_ready_i = 1;
      hrsp_ready_i = !hold_rsp;
    end
  endtask

  task automatic present(logic [2:0] op, logic [3:0] ad, logic [NB-1:0] m, logic [DW-1:0] d, bit e);
    hreq_op_i = op; hreq_addr_i = {4'd0, ad}; hreq_mask_i = m; hreq_data_i = d;
    err_in_i = e; hreq_valid_i = 1;
  endtask

  task automatic send(logic [2:0] op, logic [3:0] ad, logic [NB-1:0] m, logic [DW-1:0] d, bit e);
    bit first = 1;
    present(op, ad, m, d, e);
    do begin
      #4;
      if (first) begin cap_op = mreq_op_o; cap_mask = mreq_mask_o; cap_data = mreq_data_o; first = 0; end
      cycle();
    end while (!acc);
  endtask

  task automatic drain();
    for (int k = 0; k < 3000; k++) begin
      if (mq.size() == 0 && expq.size() == 0 && !in_seq && !mrsp_valid_i) break;
      cycle();
    end
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [DW-1:0] old5;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h5A00_0000 ^ (i * 32'h0103_0507);
      gold[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #4;
    chk(!mreq_valid_o && !hrsp_valid_o && hreq_ready_o, "R9 reset idle",
        {mreq_valid_o, 30'd0, hrsp_valid_o, hreq_ready_o}, 33'd1);
    cycle();

    send(3'd0, 4'd3, 4'hF, 32'h1122_3344, 0);
    chk(cap_op == 3'd0 && cap_mask == 4'hF && cap_data == 32'h1122_3344, "R1 full write",
        {1'b0, cap_data}, {1'b0, 32'h1122_3344});
    send(3'd4, 4'd3, 4'hF, 32'h0, 0);
    chk(cap_op == 3'd4, "R1 read", {30'd0, cap_op}, 33'd4);
    send(3'd1, 4'd3, 4'b0101, 32'hAABB_CCDD, 0);
    chk(cap_op == 3'd4, "R2 partial becomes read", {30'd0, cap_op}, 33'd4);
    drain();
    chk(mem[3] == 32'h11BB_33DD, "R3 merged word", {1'b0, mem[3]}, {1'b0, 32'h11BB_33DD});
    send(3'd0, 4'd9, 4'b1000, 32'hEE00_0000, 0);
    drain();
    send(3'd4, 4'd9, 4'hF, 32'h0, 0);
    send(3'd4, 4'd15, 4'hF, 32'h0, 0);
    drain();

    send(3'd1, 4'd7, 4'b0010, 32'h0000_9900, 1);
    chk(cap_op == 3'd1 && cap_mask == 4'b0010, "R7 error pass-through",
        {28'd0, cap_mask, 1'b0}, {28'd0, 4'b0010, 1'b0});
    drain();
    chk(!in_seq, "R7 no sequence", {32'd0, in_seq}, 33'd0);

    hold_rsp = 1;
    send(3'd4, 4'd1, 4'hF, 32'h0, 0);
    send(3'd4, 4'd2, 4'hF, 32'h0, 0);
    present(3'd4, 4'd4, 4'hF, 32'h0, 0);
    #4;
    chk(!hreq_ready_o && !mreq_valid_o, "R6 outstanding limit",
        {31'd0, hreq_ready_o, mreq_valid_o}, 33'd0);
    hold_rsp = 0;
    do cycle(); while (!acc);
    drain();

    hold_rsp = 1;
    old5 = gold[5];
    send(3'd4, 4'd5, 4'hF, 32'h0, 0);
    send(3'd1, 4'd5, 4'b0011, 32'h1234_5678, 0);
    cycle(); cycle();
    #4;
    chk(hrsp_valid_o && hrsp_data_o == old5, "R10 earlier response delivered",
        {hrsp_valid_o, hrsp_data_o}, {1'b1, old5});
    hold_rsp = 0;
    drain();

    rmode = 1;
    for (int n = 0; n < 800; n++) begin
      logic [2:0] op;
      logic [NB-1:0] m;
      case ($urandom % 3) 0: op = 3'd0; 1: op = 3'd1; default: op = 3'd4; endcase
      m = (($urandom % 3) == 0) ? 4'hF : 4'($urandom);
      send(op, 4'($urandom), m, $urandom, ($urandom % 10) == 0);
    end
    rmode = 0;
    drain();

    chk(seq_viol == 0, "R5 host stalled during sequence", {1'b0, 32'(seq_viol)}, 33'd0);
    chk(expq.size() == 0, "R4 all responses seen", {1'b0, 32'(expq.size())}, 33'd0);
    for (int i = 0; i < 16; i++)
      chk(mem[i] == gold[i], "R3 memory image", {1'b0, mem[i]}, {1'b0, gold[i]});
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule